// File: doc/BRIEF.md
# Split Serial Register Address Controller

This block generates the address stream for a 512-position serial output register. The register is treated as two 256-position halves. The cycle sequencer sends it two kinds of transfer command:

- A **full load** carries a 9-bit tap. That tap becomes the next serial address, and its top bit selects the active half.
- A **split load** carries an 8-bit tap meant for the half that is not being read. The tap is held until the reader reaches the end of the current half. The address then jumps to that tap inside the other half, so that a display line continues without a timing-critical reload.

Each cycle in which `shiftEn` is high stands for one rising serial-clock edge, and the address advances by one position. `halfSel` shows which half the current address lies in. It toggles on the shift that leaves a half's last position (255 or 511). A split load only makes sense once a full load has fixed the half. Any split load that arrives earlier is dropped and sets a sticky error flag.

Top module: `serial_tap_unit`

## Requirements
- R1: After reset `serAddr` is 0, `halfSel` is 0, `splitErr` is 0, no split tap is pending and the block is unarmed.
- R2: When `fullLoad` is high, the next cycle shows `serAddr` equal to `tapIn` and `halfSel` equal to `tapIn[8]`, and the block becomes armed.
- R3: When `shiftEn` is high and the address is not at position 255 or 511, the next cycle shows `serAddr` increased by one and `halfSel` unchanged.
- R4: When `shiftEn` is high at position 255 or 511 with no split tap pending, the address moves to the first position of the other half (255 to 256, 511 to 0) and `halfSel` toggles.
- R5: When `shiftEn` is high at position 255 or 511 with a split tap Y pending, the address becomes Y in the other half (256+Y from the lower half, Y from the upper half) and `halfSel` toggles. The pending tap is used up, so the following boundary wraps as in R4.
- R6: A split load uses only `tapIn[7:0]`, and `tapIn[8]` has no effect.
- R7: A second split load before the boundary replaces the pending tap.
- R8: A full load discards any pending split tap.
- R9: A split load while unarmed is ignored and sets `splitErr`, which stays high until reset.
- R10: A full load takes priority over `shiftEn` and `splitLoad` in the same cycle, and a split load dropped this way does not set `splitErr`. A split load that coincides with a boundary shift becomes the pending tap for the next boundary, while the boundary uses the previous one.
- R11: With no `fullLoad` and no `shiftEn`, `serAddr` and `halfSel` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| fullLoad | input | 1 | Full transfer command strobe |
| splitLoad | input | 1 | Split transfer command strobe |
| tapIn | input | 9 | Tap address for either transfer command |
| shiftEn | input | 1 | One serial-clock rising edge |
| serAddr | output | 9 | Current serial register address |
| halfSel | output | 1 | Active half (0 lower, 1 upper) |
| splitErr | output | 1 | Sticky flag for a split load made before any full load |

## Verification
The hardest situations to reach are the ones where a split load and a boundary shift meet: both strobes in the same cycle, a split replaced just before the boundary, and a full load that arrives while a split tap is pending.

Random stimulus alone rarely walks the address to 255 or 511 with the right command in flight. The bench therefore biases its random full-load taps toward positions a few steps short of a boundary and keeps the shift rate high. It also adds directed sequences that put each of these collisions on the exact boundary cycle.

// File: rtl/serial_tap_pkg.sv
package serial_tap_pkg;

  // Strobes sent from the control unit to the datapath, one set per cycle.
  typedef struct packed {
    logic loadFull;    // take the full tap and its half bit
    logic storeSplit;  // capture the low tap bits as the pending split tap
    logic step;        // count on inside the current half
    logic jumpPend;    // boundary shift that enters the pending tap
    logic jumpWrap;    // boundary shift to the start of the other half
  } tapStrobe_t;

endpackage

// File: rtl/serial_tap_ctrl.sv
module serial_tap_ctrl
  import serial_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fullLoad,
  input  logic       splitLoad,
  input  logic       shiftEn,
  input  logic       atBoundary,
  output tapStrobe_t stb,
  output logic       splitErr
);

  logic armed;
  logic pendValid;
  logic splitTaken;
  logic splitRefused;
  logic boundaryShift;

  // A full load wins the cycle; a split load only counts once armed.
  assign splitTaken    = splitLoad && !fullLoad && armed;
  assign splitRefused  = splitLoad && !fullLoad && !armed;
  assign boundaryShift = shiftEn && !fullLoad && atBoundary;

  always_comb begin
    stb            = '0;
    stb.loadFull   = fullLoad;
    stb.storeSplit = splitTaken;
    stb.step       = shiftEn && !fullLoad && !atBoundary;
    stb.jumpPend   = boundaryShift && pendValid;
    stb.jumpWrap   = boundaryShift && !pendValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      pendValid <= 1'b0;
      splitErr  <= 1'b0;
    end else begin
      if (fullLoad) begin
        armed <= 1'b1;
      end
      if (splitRefused) begin
        splitErr <= 1'b1;
      end
      if (fullLoad) begin
        pendValid <= 1'b0;
      end else if (splitTaken) begin
        pendValid <= 1'b1;
      end else if (stb.jumpPend) begin
        pendValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_tap_dp.sv
module serial_tap_dp
  import serial_tap_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapStrobe_t        stb,
  input  logic [ADDR_W-1:0] tapIn,
  output logic [ADDR_W-1:0] serAddr,
  output logic              halfSel,
  output logic              atBoundary
);

  localparam int HALF_W = ADDR_W - 1;

  logic [HALF_W-1:0] pendTap;
  logic [HALF_W-1:0] offset;
  logic              otherHalf;

  assign offset     = serAddr[HALF_W-1:0];
  assign atBoundary = &offset;
  assign otherHalf  = ~halfSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serAddr <= '0;
      halfSel <= 1'b0;
      pendTap <= '0;
    end else begin
      if (stb.storeSplit) begin
        pendTap <= tapIn[HALF_W-1:0];
      end
      if (stb.loadFull) begin
        serAddr <= tapIn;
        halfSel <= tapIn[ADDR_W-1];
      end else if (stb.jumpPend) begin
        serAddr <= {otherHalf, pendTap};
        halfSel <= otherHalf;
      end else if (stb.jumpWrap) begin
        serAddr <= {otherHalf, {HALF_W{1'b0}}};
        halfSel <= otherHalf;
      end else if (stb.step) begin
        serAddr <= {halfSel, offset + HALF_W'(1)};
      end
    end
  end

endmodule

// File: rtl/serial_tap_unit.sv
module serial_tap_unit
  import serial_tap_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fullLoad,
  input  logic              splitLoad,
  input  logic [ADDR_W-1:0] tapIn,
  input  logic              shiftEn,
  output logic [ADDR_W-1:0] serAddr,
  output logic              halfSel,
  output logic              splitErr
);

  tapStrobe_t stb;
  logic       atBoundary;

  serial_tap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fullLoad   (fullLoad),
    .splitLoad  (splitLoad),
    .shiftEn    (shiftEn),
    .atBoundary (atBoundary),
    .stb        (stb),
    .splitErr   (splitErr)
  );

  serial_tap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .tapIn      (tapIn),
    .serAddr    (serAddr),
    .halfSel    (halfSel),
    .atBoundary (atBoundary)
  );

endmodule

// File: rtl/serial_tap_chk.sv
module serial_tap_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              fullLoad,
  input logic              splitLoad,
  input logic [ADDR_W-1:0] tapIn,
  input logic              shiftEn,
  input logic [ADDR_W-1:0] serAddr,
  input logic              halfSel,
  input logic              splitErr
);

  localparam int HALF_W = ADDR_W - 1;

  logic edgeAddr;
  assign edgeAddr = &serAddr[HALF_W-1:0];

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fullLoad |=> (serAddr == $past(tapIn)) && (halfSel == $past(tapIn[ADDR_W-1]))); // R2

  AST_STEP_INSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (!fullLoad && shiftEn && !edgeAddr) |=>
      (serAddr == $past(serAddr) + ADDR_W'(1)) && $stable(halfSel)); // R3

  AST_BOUNDARY_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!fullLoad && shiftEn && edgeAddr) |=>
      (halfSel != $past(halfSel)) && (serAddr[ADDR_W-1] != $past(serAddr[ADDR_W-1]))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!fullLoad && !shiftEn) |=> $stable(serAddr) && $stable(halfSel)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    splitErr |=> splitErr); // R9

  AST_SPLIT_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (splitLoad && !fullLoad && !shiftEn) |=> $stable(serAddr)); // R6

endmodule

bind serial_tap_unit serial_tap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fullLoad  (fullLoad),
  .splitLoad (splitLoad),
  .tapIn     (tapIn),
  .shiftEn   (shiftEn),
  .serAddr   (serAddr),
  .halfSel   (halfSel),
  .splitErr  (splitErr)
);

// File: tb/serial_tap_unit_bench.sv
module serial_tap_unit_bench;

  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rstN;
  logic          fullLoad, splitLoad, shiftEn;
  logic [AW-1:0] tapIn;
  logic [AW-1:0] serAddr;
  logic          halfSel, splitErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference state, kept from the requirements.
  logic [AW-1:0] mAddr;
  logic          mHalf, mErr, mArmed, mPendV;
  logic [7:0]    mPend;

  always #4 clk = ~clk;

  serial_tap_unit u_serial_tap_unit (
    .clk(clk), .rstN(rstN), .fullLoad(fullLoad), .splitLoad(splitLoad),
    .tapIn(tapIn), .shiftEn(shiftEn), .serAddr(serAddr), .halfSel(halfSel),
    .splitErr(splitErr)
  );

  function automatic string classify(logic f, logic s, logic a, logic [AW-1:0] addr,
                                     logic pv, logic armed);
    if (f) return (s || a) ? "R10" : "R2";
    if (s && !armed) return "R9";
    if (a && addr[7:0] == 8'hFF) return pv ? "R5" : "R4";
    if (a) return "R3";
    if (s) return "R6";
    return "R11";
  endfunction

  task automatic modelStep(logic f, logic s, logic a, logic [AW-1:0] t);
    logic [AW-1:0] nAddr = mAddr;
    logic          nHalf = mHalf;
    logic          nPv   = mPendV;
    logic [7:0]    nPend = mPend;
    if (f) begin
      nAddr = t; nHalf = t[8]; nPv = 1'b0; mArmed = 1'b1;
    end else begin
      if (a && mAddr[7:0] == 8'hFF) begin
        nHalf = ~mHalf;
        nAddr = mPendV ? {~mHalf, mPend} : {~mHalf, 8'h00};
        nPv   = 1'b0;
      end else if (a) begin
        nAddr = mAddr + 9'd1;
      end
      if (s && mArmed) begin
        nPend = t[7:0]; nPv = 1'b1;
      end else if (s) begin
        mErr = 1'b1;
      end
    end
    mAddr = nAddr; mHalf = nHalf; mPendV = nPv; mPend = nPend;
  endtask

  task automatic compare(string req);
    nChecks++;
    if (serAddr !== mAddr || halfSel !== mHalf || splitErr !== mErr) begin
      nFails++;
      $display("FAIL %s: addr=%0d half=%0b err=%0b expected addr=%0d half=%0b err=%0b",
               req, serAddr, halfSel, splitErr, mAddr, mHalf, mErr);
    end
  endtask

  // Called at a negative edge: drive, advance one clock, compare at next negedge.
  task automatic cyc(logic f, logic s, logic a, logic [AW-1:0] t, string req = "");
    string tag = (req == "") ? classify(f, s, a, mAddr, mPendV, mArmed) : req;
    fullLoad = f; splitLoad = s; shiftEn = a; tapIn = t;
    modelStep(f, s, a, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic shiftN(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, '0, req);
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0; fullLoad = 0; splitLoad = 0; shiftEn = 0; tapIn = '0;
    mAddr = '0; mHalf = 0; mErr = 0; mArmed = 0; mPendV = 0; mPend = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");

    // R9: split before any full load is dropped and sets the sticky flag
    cyc(0, 1, 0, 9'h033, "R9");
    cyc(0, 0, 1, '0, "R9");
    shiftN(4, "R9");

    // R2 then R3: full load into lower half near its edge
    cyc(1, 0, 0, 9'h0FC, "R2");
    shiftN(2, "R3");
    // R6: split tap with top bit set, only low bits count
    cyc(0, 1, 0, 9'h110, "R6");
    shiftN(1, "R3");
    // R5: boundary 255 enters 256+0x10
    cyc(0, 0, 1, '0, "R5");
    // R4: next upper boundary wraps to 0 (pending consumed)
    for (int i = 0; i < 239; i++) cyc(0, 0, 1, '0, "R3");
    cyc(0, 0, 1, '0, "R4");

    // R7: second split replaces the first
    cyc(1, 0, 0, 9'h1FD, "R2");
    cyc(0, 1, 0, 9'h022, "R7");
    cyc(0, 1, 0, 9'h044, "R7");
    shiftN(2, "R3");
    cyc(0, 0, 1, '0, "R7");

    // R8: full load discards a pending split tap
    cyc(0, 1, 0, 9'h077, "R8");
    cyc(1, 0, 0, 9'h1FF, "R8");
    cyc(0, 0, 1, '0, "R8");

    // R10: full load beats shift and split in the same cycle
    cyc(1, 1, 1, 9'h0FE, "R10");
    cyc(0, 0, 1, '0, "R10");
    cyc(0, 0, 1, '0, "R10");
    // R10: split coinciding with a boundary becomes the next pending tap
    cyc(1, 0, 0, 9'h0FF, "R2");
    cyc(0, 1, 0, 9'h005, "R10");
    cyc(0, 1, 1, 9'h009, "R10");
    shiftN(250, "R3");
    cyc(0, 0, 1, '0, "R10");

    // R11: idle cycles hold
    cyc(0, 0, 0, 9'h1AB, "R11");
    cyc(0, 0, 0, 9'h000, "R11");

    // Constrained random run, taps biased near the half edges
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      logic f = (r < 2);
      logic s = ($urandom_range(0, 99) < 4);
      logic a = ($urandom_range(0, 99) < 85);
      logic [AW-1:0] t;
      if ($urandom_range(0, 1) == 1)
        t = {1'($urandom_range(0, 1)), 8'(8'hFF - $urandom_range(0, 6))};
      else
        t = AW'($urandom_range(0, 511));
      cyc(f, s, a, t);
    end

    // R1: reset returns every output and clears pending and error
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mAddr = '0; mHalf = 0; mErr = 0; mArmed = 0; mPendV = 0;
    compare("R1");
    cyc(0, 1, 0, 9'h012, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule